// File: doc/BRIEF.md
# Iterative Divide-Step Unit

This unit divides a 32-bit dividend by a 32-bit divisor, signed or unsigned, as a short series of commands rather than one long operation. No command runs for more than eight cycles, so a controller can take interrupts between them. An initialise command loads the operands and lays out a 64-bit working register whose upper half grows into the remainder and whose lower half grows into the quotient. Each step command then develops eight quotient bits, one per cycle. An adjust command finishes a signed division. The number of steps (4, 2 or 1) follows the quotient size chosen at initialisation (32, 16 or 8 bits). Smaller sizes give a shorter sequence when the caller knows the quotient fits.

The working register, a busy flag, a one-cycle done flag and a divide-by-zero flag are visible at the ports. The control is a two-state machine. In `ST_IDLE` it accepts commands. The transition *step accepted* moves it to `ST_STEP`. It stays in `ST_STEP` for eight iterations, and the transition *last iteration* returns it to `ST_IDLE`. Initialise and adjust complete in `ST_IDLE` in a single edge and cause no transition.

Each step iteration works as follows. The register shifts left by one bit. Then, depending on the remainder sign, the divisor magnitude is added to or taken from the remainder half. The trial result is kept only if it stays on the correct side of zero. The accept bit, inverted when the quotient is negative, enters at bit 0. Signed results are truncated toward zero, and the remainder carries the sign of the dividend.

Top module: `iterdiv_unit`

## Requirements
- R1: A command is taken on a rising clock edge when `cmd_valid` is high and `busy` is low. `cmd_op` encodes 2'b01 initialise, 2'b10 step, 2'b11 adjust, and 2'b00 no operation; a no-operation command leaves `work_reg` unchanged and raises no `done`. Initialise and adjust update `work_reg` at the accepting edge and raise `done` for the following cycle only. After reset, `work_reg`, `busy`, `done` and `div_zero` are all zero.
- R2: Initialise sets `work_reg` to the dividend extended to 64 bits, shifted left by a quantity set by `cmd_qsize`. The extension is sign extension when `cmd_signed` is 1 and zero extension otherwise. `cmd_qsize` = 00 selects a 32-bit quotient and no shift, 01 selects a 16-bit quotient and a shift of 16, and 10 or 11 selects an 8-bit quotient and a shift of 24.
- R3: The low bit positions vacated by that shift are all filled with the quotient sign. The quotient sign is the XOR of the sign bits of dividend and divisor in signed mode, and 0 in unsigned mode.
- R4: A step raises `busy` for exactly 8 cycles, starting the cycle after it is accepted. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R5: For an unsigned division, after 4, 2 or 1 steps (quotient size 32, 16 or 8), `work_reg[31:0]` holds the quotient and `work_reg[63:32]` holds the remainder. This holds for any dividend whose value fits in the chosen quotient size.
- R6: For a signed division, after the steps and one adjust command, `work_reg[31:0]` holds the quotient truncated toward zero. `work_reg[63:32]` holds the remainder, which is zero or has the sign of the dividend.
- R7: In signed mode with a non-negative dividend and divisor, the result is already correct after the steps, and a following adjust command leaves `work_reg` unchanged.
- R8: Any command presented while `busy` is high is ignored. It changes neither the running division nor its result.
- R9: An initialise with a zero divisor sets `div_zero`, which stays set until the next initialise. Steps with a zero divisor still end after 8 cycles each, with `done`.
- R10: The signed division of 32'h80000000 by 32'hFFFFFFFF with a 32-bit quotient yields quotient 32'h80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | Command code: 01 initialise, 10 step, 11 adjust, 00 none |
| cmd_signed | input | 1 | Signed operands (initialise only) |
| cmd_qsize | input | 2 | Quotient size: 00 = 32, 01 = 16, 1x = 8 bits (initialise only) |
| cmd_dividend | input | 32 | Dividend (initialise only) |
| cmd_divisor | input | 32 | Divisor (initialise only) |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| div_zero | output | 1 | The divisor loaded at the last initialise was zero |
| work_reg | output | 64 | Working register: remainder in the upper half, quotient in the lower |

## Verification
A wrong iteration count or a stuck state shows up on `busy` and `done` within the same step: the clock-by-clock model flags the first cycle in which either differs. A wrong accept decision or a wrong quotient-bit polarity corrupts a single quotient bit. That surfaces in `work_reg` as soon as the sequence ends, at most four steps later. Operands are chosen so that both exact divisions and borderline remainders occur. A lost divisor or sign flag after an ignored command shows up in the final quotient or remainder of the sequence that was in progress.

// File: rtl/itdiv_pkg.sv
package itdiv_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_INIT = 2'b01,
        OP_STEP = 2'b10,
        OP_ADJ  = 2'b11
    } div_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } div_state_e;

endpackage

// File: rtl/itdiv_prep.sv
module itdiv_prep #(
    parameter int DW        = 32,
    parameter int STEP_BITS = 8,
    localparam int RW       = 2 * DW
) (
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    input  logic          sgn,
    input  logic [1:0]    qsize,
    output logic [RW-1:0] work,
    output logic [DW-1:0] dmag,
    output logic          neg_rem,
    output logic          qsign,
    output logic          dz
);
    localparam int SH_MID   = DW - 2 * STEP_BITS;
    localparam int SH_SMALL = DW - STEP_BITS;

    logic          sd, sdv;
    logic [RW-1:0] ext, fill;
    int            sh;

    always_comb begin
        sd    = sgn & dividend[DW-1];
        sdv   = sgn & divisor[DW-1];
        qsign = sd ^ sdv;
        unique case (qsize)
            2'b00:   sh = 0;
            2'b01:   sh = SH_MID;
            default: sh = SH_SMALL;
        endcase
        ext     = {{DW{sd}}, dividend};
        fill    = ~({RW{1'b1}} << sh);
        work    = (ext << sh) | (qsign ? fill : '0);
        dmag    = sdv ? (DW'(0) - divisor) : divisor;
        neg_rem = sd;
        dz      = (divisor == '0);
    end

endmodule

// File: rtl/itdiv_iter.sv
module itdiv_iter #(
    parameter int DW  = 32,
    localparam int RW = 2 * DW
) (
    input  logic [RW-1:0] work_i,
    input  logic [DW-1:0] dmag,
    input  logic          sgn,
    input  logic          neg_rem,
    input  logic          qsign,
    output logic [RW-1:0] work_o
);
    logic [DW-1:0]        hi;
    logic signed [DW:0]   hx;
    logic signed [DW+1:0] cand, dm, tmp;
    logic                 acc;
    logic [DW-1:0]        newr;
    logic                 unused_bits;

    always_comb begin
        hi   = work_i[RW-1:DW];
        hx   = sgn ? {hi[DW-1], hi} : {1'b0, hi};
        cand = {hx, work_i[DW-1]};
        dm   = {2'b00, dmag};
        tmp  = neg_rem ? (cand + dm) : (cand - dm);
        acc  = neg_rem ? tmp[DW+1] : ~tmp[DW+1];
        newr = acc ? tmp[DW-1:0] : cand[DW-1:0];
        work_o = {newr, work_i[DW-2:0], acc ^ qsign};
        unused_bits = ^{tmp[DW], cand[DW+1:DW]};
    end

endmodule

// File: rtl/itdiv_fix.sv
module itdiv_fix #(
    parameter int DW  = 32,
    localparam int RW = 2 * DW
) (
    input  logic [RW-1:0] work_i,
    input  logic [DW-1:0] dmag,
    input  logic          neg_rem,
    input  logic          qsign,
    output logic [RW-1:0] work_o
);
    logic [DW-1:0] hi, lo;
    logic          corr;

    always_comb begin
        hi     = work_i[RW-1:DW];
        lo     = work_i[DW-1:0];
        corr   = neg_rem && ((hi + dmag) == '0);
        work_o = {corr ? '0 : hi, lo + DW'(qsign ^ corr)};
    end

endmodule

// File: rtl/iterdiv_unit.sv
module iterdiv_unit #(
    parameter int DW        = 32,
    parameter int STEP_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_signed,
    input  logic [1:0]       cmd_qsize,
    input  logic [DW-1:0]    cmd_dividend,
    input  logic [DW-1:0]    cmd_divisor,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    output logic [2*DW-1:0]  work_reg
);
    import itdiv_pkg::*;

    localparam int RW = 2 * DW;
    localparam int CW = $clog2(STEP_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEP_BITS - 1);

    div_state_e    state_q, state_d;
    div_op_e       op;
    logic          accept;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] work_q, init_work, iter_work, adj_work;
    logic [DW-1:0] dmag_q, init_dmag;
    logic          neg_q, qs_q, sgn_q, dz_q, done_q;
    logic          init_neg, init_qs, init_dz;

    assign op     = div_op_e'(cmd_op);
    assign accept = cmd_valid && (state_q == ST_IDLE);

    itdiv_prep #(.DW(DW), .STEP_BITS(STEP_BITS)) u_prep (
        .dividend (cmd_dividend),
        .divisor  (cmd_divisor),
        .sgn      (cmd_signed),
        .qsize    (cmd_qsize),
        .work     (init_work),
        .dmag     (init_dmag),
        .neg_rem  (init_neg),
        .qsign    (init_qs),
        .dz       (init_dz)
    );

    itdiv_iter #(.DW(DW)) u_iter (
        .work_i  (work_q),
        .dmag    (dmag_q),
        .sgn     (sgn_q),
        .neg_rem (neg_q),
        .qsign   (qs_q),
        .work_o  (iter_work)
    );

    itdiv_fix #(.DW(DW)) u_fix (
        .work_i  (work_q),
        .dmag    (dmag_q),
        .neg_rem (neg_q),
        .qsign   (qs_q),
        .work_o  (adj_work)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && op == OP_STEP) state_d = ST_STEP;
            ST_STEP: if (cnt_q == LAST)           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            dmag_q <= '0;
            neg_q  <= 1'b0;
            qs_q   <= 1'b0;
            sgn_q  <= 1'b0;
            dz_q   <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (op)
                            OP_INIT: begin
                                work_q <= init_work;
                                dmag_q <= init_dmag;
                                neg_q  <= init_neg;
                                qs_q   <= init_qs;
                                sgn_q  <= cmd_signed;
                                dz_q   <= init_dz;
                                done_q <= 1'b1;
                            end
                            OP_ADJ: begin
                                work_q <= adj_work;
                                done_q <= 1'b1;
                            end
                            OP_STEP: cnt_q <= '0;
                            OP_NONE: ;
                        endcase
                    end
                end
                ST_STEP: begin
                    work_q <= iter_work;
                    cnt_q  <= cnt_q + CW'(1);
                    if (cnt_q == LAST) done_q <= 1'b1;
                end
            endcase
        end
    end

    assign busy     = (state_q == ST_STEP);
    assign done     = done_q;
    assign div_zero = dz_q;
    assign work_reg = work_q;

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_step_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> busy);

    assert_done_after_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !neg_q && !dz_q) |-> (work_q[RW-1:DW] < dmag_q));

    assert_rem_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && neg_q && !dz_q) |-> work_q[RW-1]);

    assert_hold_operands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dmag_q) && $stable(qs_q) && $stable(neg_q) && $stable(dz_q)));

endmodule

// File: tb/test_iterdiv_unit.sv
module test_iterdiv_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n, cmd_valid, cmd_signed;
    logic [1:0]  cmd_op, cmd_qsize;
    logic [31:0] cmd_dividend, cmd_divisor;
    logic        busy, done, div_zero;
    logic [63:0] work_reg;

    int  total = 0;
    int  bad   = 0;
    int  cyc   = 0;
    int  mcnt;
    logic mdone;

    iterdiv_unit i_iterdiv_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_signed(cmd_signed), .cmd_qsize(cmd_qsize),
        .cmd_dividend(cmd_dividend), .cmd_divisor(cmd_divisor),
        .busy(busy), .done(done), .div_zero(div_zero), .work_reg(work_reg)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // behavioural timing model: remaining busy cycles and expected done
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt  <= 0;
            mdone <= 1'b0;
        end else begin
            mdone <= 1'b0;
            if (mcnt > 0) begin
                mcnt <= mcnt - 1;
                if (mcnt == 1) mdone <= 1'b1;
            end else if (cmd_valid) begin
                if (cmd_op == 2'b10)      mcnt  <= 8;
                else if (cmd_op != 2'b00) mdone <= 1'b1;
            end
        end
    end

    // compared on every clock (R4 timing, R1 done for single-edge commands)
    always @(negedge clk) begin
        if (rst_n) begin
            total = total + 1;
            if (busy !== (mcnt != 0) || done !== mdone) begin
                bad = bad + 1;
                $display("FAIL R4 handshake: actual busy=%b done=%b expected busy=%b done=%b",
                         busy, done, (mcnt != 0), mdone);
            end
        end
    end

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic sg, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_signed = sg; cmd_qsize = sz;
        cmd_dividend = a; cmd_divisor = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    function automatic logic [63:0] expect_init(input logic sg, input logic [1:0] sz,
                                                input logic [31:0] a, input logic [31:0] b);
        int sh;
        logic qs;
        logic [63:0] ext;
        sh  = (sz == 2'b00) ? 0 : (sz == 2'b01) ? 16 : 24;
        qs  = sg & (a[31] ^ b[31]);
        ext = sg ? {{32{a[31]}}, a} : {32'h0, a};
        return (ext << sh) | (qs ? ((64'd1 << sh) - 64'd1) : 64'd0);
    endfunction

    function automatic logic [63:0] expect_div(input logic sg, input logic [31:0] a,
                                               input logic [31:0] b);
        longint x, y, q, r;
        x = sg ? longint'($signed(a)) : longint'(a);
        y = sg ? longint'($signed(b)) : longint'(b);
        q = x / y;
        r = x % y;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic run_div(input logic sg, input logic [1:0] sz,
                           input logic [31:0] a, input logic [31:0] b, input string tag);
        int nsteps;
        logic [63:0] expv;
        nsteps = (sz == 2'b00) ? 4 : (sz == 2'b01) ? 2 : 1;
        issue(2'b01, sg, sz, a, b);
        check64("R2/R3 init image", work_reg, expect_init(sg, sz, a, b));
        for (int s = 0; s < nsteps; s++) begin
            issue(2'b10, sg, sz, a, b);
            wait_done();
        end
        expv = expect_div(sg, a, b);
        if (!sg) begin
            check64({"R5 unsigned ", tag}, work_reg, expv);
        end else begin
            if (!a[31] && !b[31]) check64({"R7 before adjust ", tag}, work_reg, expv);
            issue(2'b11, sg, sz, a, b);
            check64({"R6 signed ", tag}, work_reg, expv);
        end
    endtask

    initial begin
        logic [63:0] snap;
        logic [31:0] ra, rb, a, b;
        logic        sg;
        logic [1:0]  sz;

        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_signed = 1'b0;
        cmd_qsize = 2'b00; cmd_dividend = '0; cmd_divisor = '0;
        repeat (3) @(negedge clk);
        check64("R1 reset state", {busy, done, div_zero, 61'h0, work_reg}, 128'h0);
        rst_n = 1'b1;

        run_div(1'b0, 2'b00, 32'd100, 32'd7, "basic");
        run_div(1'b0, 2'b00, 32'hFFFFFFFF, 32'd1, "max");
        run_div(1'b1, 2'b00, -32'sd100, 32'd7, "neg dividend");
        run_div(1'b1, 2'b00, 32'd100, -32'sd7, "neg divisor");
        run_div(1'b1, 2'b00, -32'sd100, -32'sd7, "both neg");
        run_div(1'b1, 2'b00, -32'sd21, 32'd7, "exact neg");
        run_div(1'b1, 2'b00, 32'd21, 32'd7, "R7 exact pos");
        run_div(1'b1, 2'b10, -32'sd128, 32'd1, "size8 min");
        run_div(1'b1, 2'b01, -32'sd32768, -32'sd1, "size16 min");
        run_div(1'b0, 2'b01, 32'd65535, 32'd1, "size16 max");
        run_div(1'b1, 2'b00, 32'h80000000, 32'hFFFFFFFF, "R10 overflow");

        for (int k = 0; k < 60; k++) begin
            sg = k[0];
            sz = 2'((k / 2) % 3);
            ra = $urandom;
            rb = $urandom;
            if (sz == 2'b01)      a = sg ? {{16{ra[15]}}, ra[15:0]} : {16'h0, ra[15:0]};
            else if (sz == 2'b10) a = sg ? {{24{ra[7]}}, ra[7:0]} : {24'h0, ra[7:0]};
            else                  a = ra;
            if (k % 3 != 2) begin
                b = (rb % 32'd50) + 32'd1;
                if (sg && rb[31]) b = 32'd0 - b;
            end else begin
                b = rb;
            end
            if (b == 32'd0) b = 32'd1;
            run_div(sg, sz, a, b, "random");
        end

        // R8: commands during a step are ignored
        issue(2'b01, 1'b0, 2'b00, 32'd1000, 32'd3);
        for (int s = 0; s < 4; s++) begin
            issue(2'b10, 1'b0, 2'b00, 32'd0, 32'd0);
            issue(2'b01, 1'b1, 2'b10, 32'hDEADBEEF, 32'd5);
            issue(2'b11, 1'b0, 2'b00, 32'd0, 32'd0);
            wait_done();
        end
        check64("R8 ignored while busy", work_reg, {32'd1, 32'd333});

        // R1: no-operation command changes nothing
        snap = work_reg;
        issue(2'b00, 1'b1, 2'b01, 32'h12345678, 32'd9);
        @(negedge clk);
        check64("R1 no-op", work_reg, snap);

        // R9: zero divisor
        issue(2'b01, 1'b0, 2'b00, 32'd77, 32'd0);
        check64("R9 flag set", {63'h0, div_zero}, 64'd1);
        for (int s = 0; s < 4; s++) begin
            issue(2'b10, 1'b0, 2'b00, 32'd0, 32'd0);
            wait_done();
        end
        check64("R9 flag held", {63'h0, div_zero}, 64'd1);
        run_div(1'b0, 2'b00, 32'd77, 32'd5, "after zero");
        check64("R9 flag cleared", {63'h0, div_zero}, 64'd0);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule